// File: doc/BRIEF.md
# Forty-Column Text Pixel Generator

This block produces the colour code of every pixel in a 40-column by 24-row character text screen. Each character cell is 6 pixels wide and 8 lines tall, so the active window is 240 by 192 pixels. An external timing generator supplies a horizontal pixel counter and a line counter. From these the block reads one character code per cell from a name table in video memory. It then reads the matching 8-bit pattern row from a pattern table and shifts out the six left-most bits of that row as pixels.

Every shown pixel is given a colour from a single colour register. A set pattern bit takes the upper nibble, which is the text colour. A clear bit takes the lower nibble, which is the backdrop colour. A text colour of 0 means transparent, so the backdrop shows through. Anything outside the active window, and the whole screen while the display enable is low, shows the backdrop. The next character is fetched during the six pixel times of the current one, so the pixels of a line come out without gaps. Video memory is read through a synchronous port with one clock of latency.

Top module: `text40_pixgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_color` is 0 after that edge and `vram_rd` is low.
- R2: `pix_color` is registered. After the edge that samples a position (`hcount`, `vcount`), it shows that position's colour. Positions with `hcount` < ACT_START (default 8), or `hcount` >= ACT_START+240, or `vcount` >= 192 show `color_reg[3:0]`.
- R3: While `display_en` is 0, every position shows `color_reg[3:0]`.
- R4: Inside the window, with x = `hcount`-ACT_START and y = `vcount`, the pixel is bit 7-(x mod 6) of the pattern byte for column x/6. A 1 shows `color_reg[7:4]` and a 0 shows `color_reg[3:0]`.
- R5: The name byte for column c of line y is read at address `name_base`*1024 + (y/8)*40 + c. This read is issued in the cycle where `hcount` = ACT_START-6+6c.
- R6: The pattern byte is read at address `pat_base`*2048 + code*8 + (y mod 8), where code is the name byte just read. This read is issued in the cycle where `hcount` = ACT_START-4+6c.
- R7: Bits 1 and 0 of every pattern byte never reach the output.
- R8: When `color_reg[7:4]` is 0, set pattern bits show `color_reg[3:0]`. As a result, the output is never 0 unless the backdrop is 0.
- R9: `vram_rd` is high only in the two read cycles of each cell on lines with `vcount` < 192, and never in two consecutive cycles. `vram_data` is taken one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount | input | HW (9) | Horizontal pixel counter from the timing generator |
| vcount | input | VW (9) | Line counter from the timing generator |
| name_base | input | 4 | Name table base, address bits 13..10 |
| pat_base | input | 3 | Pattern table base, address bits 13..11 |
| color_reg | input | 8 | Text colour [7:4], backdrop colour [3:0] |
| display_en | input | 1 | 1 shows the text, 0 shows only the backdrop |
| vram_addr | output | 14 | Video memory read address |
| vram_rd | output | 1 | Video memory read strobe |
| vram_data | input | 8 | Read data, valid one cycle after the read |
| pix_color | output | 4 | Colour code of the current pixel |

## Verification
The hardest case to reach from the ports is the hand-over at a cell boundary. There the pattern for the next character must already be loaded when the last pixel of the current one leaves, while two reads of video memory with one-cycle latency are still in flight for the following cell. The bench sweeps whole lines, one per table entry. It uses a hashed memory image in which neighbouring codes and pattern rows differ, and whose low two bits are often set. Any slip in fetch phase, any wrong base or row offset, or any leak of the dropped bits then changes a pixel. The table includes the first and last character rows and the largest base values. It also covers a transparent text colour, a disabled display, lines below the window and a reset asserted in the middle of a line.

// File: rtl/text40_pkg.sv
// Shared types for the forty-column text pixel generator.
// Assumes 4-bit colour codes and byte-wide video memory.
package text40_pkg;
    typedef logic [3:0] color_t;
    typedef logic [7:0] vbyte_t;
    localparam int VADDR_W = 14;
    localparam int CELL_H  = 8;
endpackage

// File: rtl/t40_fetch_seq.sv
// Fetch sequencer: walks the cells of one line and reads each name byte,
// then its pattern row, from video memory during the previous cell's pixels.
// Assumes a synchronous memory with one cycle of read latency and CELL_W >= 6.
module t40_fetch_seq
    import text40_pkg::*;
#(
    parameter int HW        = 9,
    parameter int VW        = 9,
    parameter int ACT_START = 8,
    parameter int COLS      = 40,
    parameter int ROWS      = 24,
    parameter int CELL_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HW-1:0]      hcount,
    input  logic [VW-1:0]      vcount,
    input  logic [3:0]         name_base,
    input  logic [2:0]         pat_base,
    input  vbyte_t             vram_data,
    output logic [VADDR_W-1:0] vram_addr,
    output logic               vram_rd,
    output logic               pat_load,
    output vbyte_t             pat_byte
);
    localparam int ACT_H       = ROWS * CELL_H;
    localparam int FETCH_START = ACT_START - CELL_W;
    localparam int PH_W        = $clog2(CELL_W);
    localparam int COL_W       = $clog2(COLS);
    localparam int ROW_W       = VW - 3;

    logic             run;
    logic [PH_W-1:0]  phase;
    logic [COL_W-1:0] col;
    vbyte_t           name_q;
    logic             start;
    logic [ROW_W-1:0] row;
    logic [9:0]       name_off;
    logic             last_ph;

    assign start    = (hcount == HW'(FETCH_START - 1)) && (vcount < VW'(ACT_H));
    assign row      = vcount[VW-1:3];
    assign name_off = 10'(32'(row) * COLS + 32'(col));
    assign last_ph  = (phase == PH_W'(CELL_W - 1));

    // Phase and column counters across the fetch window of an active line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            phase <= '0;
            col   <= '0;
        end else if (start) begin
            run   <= 1'b1;
            phase <= '0;
            col   <= '0;
        end else if (run) begin
            if (last_ph) begin
                phase <= '0;
                col   <= col + 1'b1;
                if (col == COL_W'(COLS - 1)) run <= 1'b0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Capture the name byte and the pattern byte as they return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            name_q   <= '0;
            pat_byte <= '0;
        end else if (run) begin
            if (phase == PH_W'(1)) name_q   <= vram_data;
            if (phase == PH_W'(3)) pat_byte <= vram_data;
        end
    end

    // Address selection: name read in phase 0, pattern read in phase 2.
    always_comb begin
        if (phase == PH_W'(0)) vram_addr = {name_base, name_off};
        else                   vram_addr = {pat_base, name_q, vcount[2:0]};
    end

    assign vram_rd  = run && ((phase == PH_W'(0)) || (phase == PH_W'(2)));
    assign pat_load = run && last_ph;
endmodule

// File: rtl/t40_shifter.sv
// Pattern shifter: loads the shown bits of a pattern byte at a cell start
// and presents one bit per clock, left-most pixel first.
// Assumes the byte's MSB is the left-most pixel; low unused bits are dropped.
module t40_shifter
    import text40_pkg::*;
#(
    parameter int CELL_W = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  vbyte_t pat_byte,
    output logic   bit_out
);
    logic [CELL_W-1:0] sh;

    // Load at the cell boundary, otherwise shift toward the output bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh <= '0;
        else if (load) sh <= pat_byte[7 -: CELL_W];
        else           sh <= {sh[CELL_W-2:0], 1'b0};
    end

    assign bit_out = sh[CELL_W-1];
endmodule

// File: rtl/t40_color_out.sv
// Colour stage: maps a pattern bit to text or backdrop colour and registers it.
// Assumes colour code 0 is transparent and falls through to the backdrop.
module t40_color_out
    import text40_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_win,
    input  logic       display_en,
    input  logic       pix_bit,
    input  logic [7:0] color_reg,
    output color_t     pix_color
);
    color_t bd;
    color_t fg;

    assign bd = color_reg[3:0];
    assign fg = (color_reg[7:4] == 4'd0) ? bd : color_reg[7:4];

    // Output register: text colour only for set bits inside an enabled window.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pix_color <= '0;
        else if (in_win && display_en && pix_bit) pix_color <= fg;
        else                                    pix_color <= bd;
    end
endmodule

// File: rtl/text40_pixgen.sv
// Top of the forty-column text pixel generator: fetch sequencer, pattern
// shifter and colour stage. Assumes the timing generator holds vcount steady
// across a line and that ACT_START >= CELL_W + 1.
module text40_pixgen
    import text40_pkg::*;
#(
    parameter int HW        = 9,
    parameter int VW        = 9,
    parameter int ACT_START = 8,
    parameter int COLS      = 40,
    parameter int ROWS      = 24,
    parameter int CELL_W    = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [HW-1:0] hcount,
    input  logic [VW-1:0] vcount,
    input  logic [3:0]   name_base,
    input  logic [2:0]   pat_base,
    input  logic [7:0]   color_reg,
    input  logic         display_en,
    output logic [13:0]  vram_addr,
    output logic         vram_rd,
    input  logic [7:0]   vram_data,
    output logic [3:0]   pix_color
);
    localparam int ACT_W = COLS * CELL_W;
    localparam int ACT_H = ROWS * CELL_H;

    logic   pat_load;
    vbyte_t pat_byte;
    logic   pix_bit;
    logic   in_win;

    assign in_win = (hcount >= HW'(ACT_START)) && (hcount < HW'(ACT_START + ACT_W))
                 && (vcount < VW'(ACT_H));

    t40_fetch_seq #(
        .HW(HW), .VW(VW), .ACT_START(ACT_START),
        .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .name_base(name_base), .pat_base(pat_base), .vram_data(vram_data),
        .vram_addr(vram_addr), .vram_rd(vram_rd),
        .pat_load(pat_load), .pat_byte(pat_byte)
    );

    t40_shifter #(.CELL_W(CELL_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(pat_load),
        .pat_byte(pat_byte), .bit_out(pix_bit)
    );

    t40_color_out u_color (
        .clk(clk), .rst_n(rst_n), .in_win(in_win), .display_en(display_en),
        .pix_bit(pix_bit), .color_reg(color_reg), .pix_color(pix_color)
    );
endmodule

// File: rtl/t40_pixgen_chk.sv
// Checker for text40_pixgen, attached by bind. Observes ports only.
module t40_pixgen_chk #(
    parameter int HW        = 9,
    parameter int VW        = 9,
    parameter int ACT_START = 8,
    parameter int COLS      = 40,
    parameter int ROWS      = 24,
    parameter int CELL_W    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] hcount,
    input logic [VW-1:0] vcount,
    input logic [7:0]    color_reg,
    input logic          display_en,
    input logic          vram_rd,
    input logic [3:0]    pix_color
);
    localparam int ACT_W   = COLS * CELL_W;
    localparam int ACT_H   = ROWS * 8;
    localparam int F_START = ACT_START - CELL_W;

    logic armed;
    logic win;

    // Arms the output checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign win = (hcount >= HW'(ACT_START)) && (hcount < HW'(ACT_START + ACT_W))
              && (vcount < VW'(ACT_H));

    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> pix_color == 4'd0);

    p_border_bd_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(win) |-> pix_color == $past(color_reg[3:0]));

    p_blank_bd_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(display_en) |-> pix_color == $past(color_reg[3:0]));

    p_rd_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |-> (vcount < VW'(ACT_H)) && (hcount >= HW'(F_START))
                    && (hcount < HW'(F_START + ACT_W)));

    p_no_transp_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(color_reg[3:0]) != 4'd0) |-> pix_color != 4'd0);

    p_rd_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |=> !vram_rd);
endmodule

bind text40_pixgen t40_pixgen_chk #(
    .HW(HW), .VW(VW), .ACT_START(ACT_START),
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W)
) u_chk (.*);

// File: tb/tb_text40_pixgen.sv
module tb_text40_pixgen;
    localparam int H_TOTAL = 260;
    localparam int ACT     = 8;
    localparam int FST     = ACT - 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  hcount = '0;
    logic [8:0]  vcount = '0;
    logic [3:0]  name_base = '0;
    logic [2:0]  pat_base = '0;
    logic [7:0]  color_reg = '0;
    logic        display_en = 1'b0;
    logic [13:0] vram_addr;
    logic        vram_rd;
    logic [7:0]  vram_data = '0;
    logic [3:0]  pix_color;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    text40_pixgen dut (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .name_base(name_base), .pat_base(pat_base), .color_reg(color_reg),
        .display_en(display_en), .vram_addr(vram_addr), .vram_rd(vram_rd),
        .vram_data(vram_data), .pix_color(pix_color)
    );

    // Hashed memory image: low pattern bits are frequently set.
    function automatic logic [7:0] vmem(input logic [13:0] a);
        logic [7:0] m;
        m = 8'(a[7:0] * 8'd37);
        return m ^ {a[13:8], a[9:8]} ^ 8'h5A;
    endfunction

    always @(posedge clk) vram_data <= vmem(vram_addr);

    // y[24:16] nb[15:12] pb[11:9] colour[8:1] en[0]
    localparam logic [24:0] VECS [0:7] = '{
        {9'd0,   4'd0,  3'd1, 8'hF4, 1'b1},
        {9'd13,  4'd6,  3'd2, 8'h1A, 1'b1},
        {9'd100, 4'd15, 3'd7, 8'h52, 1'b1},
        {9'd191, 4'd3,  3'd0, 8'hE1, 1'b1},
        {9'd57,  4'd9,  3'd5, 8'h07, 1'b1},
        {9'd40,  4'd2,  3'd3, 8'h9C, 1'b0},
        {9'd192, 4'd1,  3'd1, 8'hB5, 1'b1},
        {9'd199, 4'd4,  3'd6, 8'h30, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (h=%0d y=%0d)",
                     req, act, exp, hcount, vcount);
        end
    endtask

    function automatic logic [13:0] name_addr(input int y, input int c);
        return 14'(name_base * 1024 + (y / 8) * 40 + c);
    endfunction

    // Expected colour at horizontal position h of the current line.
    function automatic logic [3:0] epix(input int h, input int y);
        logic [3:0] bd, tc;
        logic [7:0] code, pat;
        int x;
        bd = color_reg[3:0];
        tc = (color_reg[7:4] == 4'd0) ? bd : color_reg[7:4];
        if (!display_en || h < ACT || h >= ACT + 240 || y >= 192) return bd;
        x    = h - ACT;
        code = vmem(name_addr(y, x / 6));
        pat  = vmem(14'(pat_base * 2048 + code * 8 + y % 8));
        return pat[7 - x % 6] ? tc : bd;
    endfunction

    task automatic run_line(input logic [24:0] v);
        int y;
        y          = int'(v[24:16]);
        vcount     = v[24:16];
        name_base  = v[15:12];
        pat_base   = v[11:9];
        color_reg  = v[8:1];
        display_en = v[0];
        for (int h = 0; h < H_TOTAL; h++) begin
            @(negedge clk);
            // R2 R3 R4 R7 R8: registered pixel of the previous position
            if (h > 0) chk(pix_color == epix(h - 1, y), "R4/R2/R3/R7/R8",
                           int'(pix_color), int'(epix(h - 1, y)));
            hcount = 9'(h);
            #1;
            begin
                int f;
                f = h - FST;
                if (y < 192 && f >= 0 && f < 240 && f % 6 == 0) begin
                    chk(vram_rd == 1'b1, "R9", int'(vram_rd), 1);
                    chk(vram_addr == name_addr(y, f / 6), "R5",
                        int'(vram_addr), int'(name_addr(y, f / 6)));
                end else if (y < 192 && f >= 0 && f < 240 && f % 6 == 2) begin
                    logic [13:0] pa;
                    pa = 14'(pat_base * 2048 + vmem(name_addr(y, f / 6)) * 8 + y % 8);
                    chk(vram_rd == 1'b1, "R9", int'(vram_rd), 1);
                    chk(vram_addr == pa, "R6", int'(vram_addr), int'(pa));
                end else begin
                    chk(vram_rd == 1'b0, "R9", int'(vram_rd), 0);
                end
            end
        end
        @(negedge clk);
        chk(pix_color == epix(H_TOTAL - 1, y), "R2",
            int'(pix_color), int'(epix(H_TOTAL - 1, y)));
    endtask

    initial begin
        color_reg = 8'hA5;
        repeat (3) @(negedge clk);
        chk(pix_color == 4'd0, "R1", int'(pix_color), 0);
        chk(vram_rd == 1'b0, "R1", int'(vram_rd), 0);
        rst_n = 1'b1;

        foreach (VECS[i]) run_line(VECS[i]);

        // R1: reset in the middle of a fetching line
        vcount = 9'd20; display_en = 1'b1; color_reg = 8'h6B;
        for (int h = 0; h < 100; h++) begin
            @(negedge clk);
            hcount = 9'(h);
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk(pix_color == 4'd0, "R1", int'(pix_color), 0);
        chk(vram_rd == 1'b0, "R1", int'(vram_rd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        hcount = '0;

        // Recovery after reset, then a repeat with a transparent text colour (R8)
        run_line(VECS[2]);
        run_line({9'd191, 4'd15, 3'd7, 8'h0E, 1'b1});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule